// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block is a synchronous behavioural model of a three-wire serial nonvolatile memory slave. A host drives chip select, a serial clock and a data input, and reads a data output. All four serial pins are sampled by a faster system clock. Each frame opens with a start bit, then a two-bit opcode, then an address field. Depending on the opcode, data bits follow or read data is shifted back out. An organization input selects how the storage is viewed: as 128 bytes with 7-bit addresses, or as 64 sixteen-bit words with 6-bit addresses.

Every command that changes the array is guarded by a write-enable latch. That latch is clear after reset. A programming command is committed by the falling edge of chip select. This starts a self-timed busy period whose length is a parameter counted in system clock cycles. While that period runs, the host can raise chip select and poll the data output for a ready/busy indication.

Top module: `uwire_eeprom`

## Requirements
- R1: A frame begins at the first serial clock rising edge that samples data in high while chip select is high. Zeros sent before that edge are ignored. Dropping chip select at any point abandons the current frame, and a frame cut short this way changes nothing.
- R2: Opcode 10 is a read. After the last address bit, data out shows one dummy 0. On each following serial clock rising edge it shows the next bit of the addressed word, most significant bit first.
- R3: With the organization input low, words are 8 bits and addresses 7 bits. With it high, words are 16 bits and addresses 6 bits. Sixteen-bit word a holds its low byte at byte address 2a and its high byte at byte address 2a+1.
- R4: After reset the write-enable latch is clear. While it is clear, opcodes 01 and 11 and the write-all and erase-all commands change no data and start no busy period.
- R5: Opcode 01 is a write. The falling edge of chip select after the data bits starts programming, and the addressed word holds the data once the busy period ends.
- R6: The data word is taken from the last 8 (or 16) data bits shifted in. If fewer bits arrive, they fill the low bits and the high bits are 0.
- R7: Opcode 11 sets every bit of the addressed word to 1. Opcode 00 with the top two address bits 10 sets every bit of the whole array to 1. Reset also leaves the array all ones.
- R8: Opcode 00 with the top two address bits 01 loads the data word that follows into every word of the array.
- R9: After programming starts, data out shows 0 while chip select is high and programming is in progress, and 1 once it has finished. While chip select is low, data out is 0.
- R10: A serial clock rising edge that samples chip select high and data in high removes the ready/busy indication from data out.
- R11: The busy period lasts exactly PROG_CYCLES system clock cycles. A frame begun while busy is ignored.
- R12: Opcode 00 with the top two address bits 11 sets the write-enable latch, and with 00 it clears the latch. The latch stays in its state until the other command or reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock that samples the serial pins |
| rst_ni | input | 1 | Active-low asynchronous reset |
| csel_i | input | 1 | Chip select, active high |
| sclk_i | input | 1 | Serial clock from the host |
| sdin_i | input | 1 | Serial data from the host |
| wide_i | input | 1 | Organization select: 0 gives 8-bit words, 1 gives 16-bit words |
| sdout_o | output | 1 | Serial read data and ready/busy status |

## Verification
The hardest situation to reach is a second frame that arrives while a programming period is still running. It must be ignored, and its start bit must still clear the ready indication. The bench makes the busy period longer than a complete write frame. It then sends a second write straight after the first has been committed, and afterwards reads both addresses back. A second hard case is the three-way interplay of chip select, data in and the status flag. The bench therefore checks the busy value, the ready value and the cleared value of data out within a single chip-select-high interval.

// File: rtl/uwe_pkg.sv
package uwe_pkg;
   localparam int BYTE_W = 8;
   localparam int WORD_W = 2 * BYTE_W;

   localparam logic [1:0] OP_EXT   = 2'b00;
   localparam logic [1:0] OP_WRITE = 2'b01;
   localparam logic [1:0] OP_READ  = 2'b10;
   localparam logic [1:0] OP_ERASE = 2'b11;

   localparam logic [1:0] EX_LOCK  = 2'b00;
   localparam logic [1:0] EX_FILL  = 2'b01;
   localparam logic [1:0] EX_WIPE  = 2'b10;
   localparam logic [1:0] EX_ARM   = 2'b11;

   typedef enum logic [1:0] {PK_WRITE, PK_FILL, PK_ERASE, PK_WIPE} prog_kind_t;
   typedef enum logic [2:0] {FS_IDLE, FS_HDR, FS_DATA, FS_ARMED, FS_READ, FS_DONE} frame_st_t;
endpackage

// File: rtl/uwe_sync.sv
module uwe_sync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic lvl_o,
   output logic rise_o,
   output logic fall_o
);
   logic [STAGES-1:0] pipe_q;
   logic              last_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pipe_q <= '0;
         last_q <= 1'b0;
      end else begin
         pipe_q <= {pipe_q[STAGES-2:0], d_i};
         last_q <= pipe_q[STAGES-1];
      end
   end

   assign lvl_o  = pipe_q[STAGES-1];
   assign rise_o = pipe_q[STAGES-1] & ~last_q;
   assign fall_o = ~pipe_q[STAGES-1] & last_q;
endmodule

// File: rtl/uwe_prog.sv
module uwe_prog
   import uwe_pkg::*;
#(
   parameter int BYTE_AW     = 7,
   parameter int PROG_CYCLES = 400
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               wide_i,
   input  logic               go_i,
   input  prog_kind_t         kind_i,
   input  logic [BYTE_AW-1:0] addr_i,
   input  logic [WORD_W-1:0]  data_i,
   input  logic [BYTE_AW-1:0] rd_addr_i,
   output logic               busy_o,
   output logic [WORD_W-1:0]  rd_word_o
);
   localparam int DEPTH = 1 << BYTE_AW;
   localparam int CW    = $clog2(PROG_CYCLES + 1);

   logic [BYTE_W-1:0]  mem_q [DEPTH];
   logic [BYTE_W-1:0]  nxt   [DEPTH];
   logic [CW-1:0]      cnt_q;
   prog_kind_t         kind_q;
   logic [BYTE_AW-1:0] addr_q;
   logic [WORD_W-1:0]  data_q;
   logic               wide_q;
   logic               commit;

   assign commit = busy_o && (cnt_q == '0);

   for (genvar i = 0; i < DEPTH; i++) begin : g_lane
      localparam logic [BYTE_AW-1:0] IDX = BYTE_AW'(i);
      logic              hit;
      logic [BYTE_W-1:0] lane;
      assign hit  = wide_q ? (addr_q[BYTE_AW-2:0] == IDX[BYTE_AW-1:1]) : (addr_q == IDX);
      assign lane = (wide_q && IDX[0]) ? data_q[WORD_W-1:BYTE_W] : data_q[BYTE_W-1:0];
      always_comb begin
         unique case (kind_q)
            PK_WRITE: nxt[i] = hit ? lane : mem_q[i];
            PK_FILL:  nxt[i] = lane;
            PK_ERASE: nxt[i] = hit ? '1 : mem_q[i];
            default:  nxt[i] = '1;
         endcase
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         busy_o <= 1'b0;
         cnt_q  <= '0;
         kind_q <= PK_WRITE;
         addr_q <= '0;
         data_q <= '0;
         wide_q <= 1'b0;
         for (int j = 0; j < DEPTH; j++) mem_q[j] <= '1;
      end else if (go_i && !busy_o) begin
         busy_o <= 1'b1;
         cnt_q  <= CW'(PROG_CYCLES - 1);
         kind_q <= kind_i;
         addr_q <= addr_i;
         data_q <= data_i;
         wide_q <= wide_i;
      end else if (commit) begin
         busy_o <= 1'b0;
         for (int j = 0; j < DEPTH; j++) mem_q[j] <= nxt[j];
      end else if (busy_o) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign rd_word_o = wide_i ? {mem_q[{rd_addr_i[BYTE_AW-2:0], 1'b1}], mem_q[{rd_addr_i[BYTE_AW-2:0], 1'b0}]}
                             : {{BYTE_W{1'b0}}, mem_q[rd_addr_i]};
endmodule

// File: rtl/uwe_frame.sv
module uwe_frame
   import uwe_pkg::*;
#(
   parameter int BYTE_AW = 7
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               cs_lvl_i,
   input  logic               cs_fall_i,
   input  logic               sk_rise_i,
   input  logic               di_lvl_i,
   input  logic               wide_i,
   input  logic               busy_i,
   input  logic [WORD_W-1:0]  rd_word_i,
   output logic [BYTE_AW-1:0] rd_addr_o,
   output logic               go_o,
   output prog_kind_t         kind_o,
   output logic [BYTE_AW-1:0] addr_o,
   output logic [WORD_W-1:0]  data_o,
   output logic               wen_o,
   output logic               dout_o
);
   localparam int HB    = 2 + BYTE_AW;
   localparam int CNT_W = $clog2(HB + 1);

   frame_st_t          st_q;
   logic [HB-2:0]      hdr_q;
   logic [HB-1:0]      nxt;
   logic [CNT_W-1:0]   cnt_q;
   logic [CNT_W-1:0]   cnt_last;
   logic [1:0]         op, ex;
   logic [BYTE_AW-1:0] dec_addr;
   logic [WORD_W-1:0]  data_q;
   logic [WORD_W:0]    out_q;
   logic               stat_q;

   assign nxt      = {hdr_q, di_lvl_i};
   assign cnt_last = wide_i ? CNT_W'(HB - 2) : CNT_W'(HB - 1);
   assign op       = wide_i ? nxt[HB-2 -: 2] : nxt[HB-1 -: 2];
   assign ex       = wide_i ? nxt[HB-4 -: 2] : nxt[HB-3 -: 2];
   assign dec_addr = wide_i ? {1'b0, nxt[BYTE_AW-2:0]} : nxt[BYTE_AW-1:0];
   assign rd_addr_o = dec_addr;
   assign data_o   = wide_i ? data_q : {{BYTE_W{1'b0}}, data_q[BYTE_W-1:0]};
   assign go_o     = cs_fall_i && (st_q == FS_DATA || st_q == FS_ARMED) && wen_o && !busy_i;
   assign dout_o   = cs_lvl_i && (stat_q ? !busy_i : (st_q == FS_READ && out_q[WORD_W]));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q   <= FS_IDLE;
         hdr_q  <= '0;
         cnt_q  <= '0;
         data_q <= '0;
         out_q  <= '0;
         stat_q <= 1'b0;
         wen_o  <= 1'b0;
         kind_o <= PK_WRITE;
         addr_o <= '0;
      end else begin
         if (go_o) stat_q <= 1'b1;
         else if (cs_lvl_i && sk_rise_i && di_lvl_i) stat_q <= 1'b0;

         if (!cs_lvl_i) begin
            st_q <= FS_IDLE;
         end else if (sk_rise_i) begin
            unique case (st_q)
               FS_IDLE: if (di_lvl_i && !busy_i) begin
                  st_q  <= FS_HDR;
                  cnt_q <= '0;
               end
               FS_HDR: begin
                  hdr_q <= nxt[HB-2:0];
                  cnt_q <= cnt_q + 1'b1;
                  if (cnt_q == cnt_last) begin
                     addr_o <= dec_addr;
                     data_q <= '0;
                     unique case (op)
                        OP_READ: begin
                           st_q  <= FS_READ;
                           out_q <= wide_i ? {1'b0, rd_word_i}
                                           : {1'b0, rd_word_i[BYTE_W-1:0], {BYTE_W{1'b0}}};
                        end
                        OP_WRITE: begin st_q <= FS_DATA;  kind_o <= PK_WRITE; end
                        OP_ERASE: begin st_q <= FS_ARMED; kind_o <= PK_ERASE; end
                        default: unique case (ex)
                           EX_ARM:  begin st_q <= FS_DONE;  wen_o <= 1'b1; end
                           EX_LOCK: begin st_q <= FS_DONE;  wen_o <= 1'b0; end
                           EX_FILL: begin st_q <= FS_DATA;  kind_o <= PK_FILL; end
                           default: begin st_q <= FS_ARMED; kind_o <= PK_WIPE; end
                        endcase
                     endcase
                  end
               end
               FS_DATA: data_q <= {data_q[WORD_W-2:0], di_lvl_i};
               FS_READ: out_q  <= {out_q[WORD_W-1:0], 1'b0};
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/uwire_eeprom.sv
module uwire_eeprom
   import uwe_pkg::*;
#(
   parameter int BYTE_AW     = 7,
   parameter int PROG_CYCLES = 400,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic csel_i,
   input  logic sclk_i,
   input  logic sdin_i,
   input  logic wide_i,
   output logic sdout_o
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (PROG_CYCLES < 2) begin : g_bad_prog
      $error("PROG_CYCLES must be at least 2");
   end
   if (BYTE_AW < 3 || BYTE_AW > 10) begin : g_bad_aw
      $error("BYTE_AW out of range");
   end

   logic cs_lvl, cs_fall, cs_rise_nc;
   logic sk_lvl_nc, sk_rise, sk_fall_nc;
   logic di_lvl, di_rise_nc, di_fall_nc;
   logic go, busy, wen;
   prog_kind_t         kind;
   logic [BYTE_AW-1:0] addr, rd_addr;
   logic [WORD_W-1:0]  data, rd_word;

   uwe_sync #(.STAGES(SYNC_STAGES)) u_cs (.clk_i, .rst_ni, .d_i(csel_i),
      .lvl_o(cs_lvl), .rise_o(cs_rise_nc), .fall_o(cs_fall));
   uwe_sync #(.STAGES(SYNC_STAGES)) u_sk (.clk_i, .rst_ni, .d_i(sclk_i),
      .lvl_o(sk_lvl_nc), .rise_o(sk_rise), .fall_o(sk_fall_nc));
   uwe_sync #(.STAGES(SYNC_STAGES)) u_di (.clk_i, .rst_ni, .d_i(sdin_i),
      .lvl_o(di_lvl), .rise_o(di_rise_nc), .fall_o(di_fall_nc));

   uwe_frame #(.BYTE_AW(BYTE_AW)) u_frame (
      .clk_i, .rst_ni,
      .cs_lvl_i(cs_lvl), .cs_fall_i(cs_fall), .sk_rise_i(sk_rise), .di_lvl_i(di_lvl),
      .wide_i, .busy_i(busy), .rd_word_i(rd_word), .rd_addr_o(rd_addr),
      .go_o(go), .kind_o(kind), .addr_o(addr), .data_o(data),
      .wen_o(wen), .dout_o(sdout_o));

   uwe_prog #(.BYTE_AW(BYTE_AW), .PROG_CYCLES(PROG_CYCLES)) u_prog (
      .clk_i, .rst_ni, .wide_i, .go_i(go), .kind_i(kind), .addr_i(addr),
      .data_i(data), .rd_addr_i(rd_addr), .busy_o(busy), .rd_word_o(rd_word));
endmodule

// File: rtl/uwe_check.sv
module uwe_check #(
   parameter int PROG_CYCLES = 400
) (
   input logic clk_i,
   input logic rst_ni,
   input logic cs_lvl,
   input logic go,
   input logic busy,
   input logic wen,
   input logic sdout
);
   localparam int CW = $clog2(PROG_CYCLES + 2);
   logic [CW-1:0] bcnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) bcnt_q <= '0;
      else         bcnt_q <= busy ? bcnt_q + 1'b1 : '0;
   end

   assert_go_needs_wen_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      go |-> wen);
   assert_go_starts_busy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      go |=> busy);
   assert_no_go_while_busy_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      go |-> !busy);
   assert_busy_length_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(busy) |-> (bcnt_q == CW'(PROG_CYCLES)));
   assert_quiet_deselect_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cs_lvl |-> !sdout);
   assert_wen_set_idle_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(wen) |-> !busy);
endmodule

bind uwire_eeprom uwe_check #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
   .clk_i(clk_i), .rst_ni(rst_ni), .cs_lvl(cs_lvl), .go(go),
   .busy(busy), .wen(wen), .sdout(sdout_o));

// File: tb/uwire_eeprom_test.sv
module uwire_eeprom_test;
   localparam int CLK_PERIOD = 10;
   localparam int PROG = 400;

   logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sk = 1'b0, di = 1'b0, wide = 1'b0;
   logic dout;
   int   nchk = 0, nerr = 0;
   bit   done = 1'b0;

   uwire_eeprom #(.PROG_CYCLES(PROG)) uut (.clk_i(clk), .rst_ni(rst_n), .csel_i(cs),
      .sclk_i(sk), .sdin_i(di), .wide_i(wide), .sdout_o(dout));

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic wclk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic sk_bit(input logic b);
      di = b; wclk(4); sk = 1'b1; wclk(4); sk = 1'b0; wclk(4);
   endtask

   task automatic send(input logic [31:0] v, input int n);
      for (int i = n - 1; i >= 0; i--) sk_bit(v[i]);
   endtask

   task automatic open_f();  cs = 1'b1; wclk(4); endtask
   task automatic close_f(); cs = 1'b0; di = 1'b0; wclk(6); endtask
   task automatic wait_prog(); wclk(PROG + 20); endtask

   function automatic int aw(); return wide ? 6 : 7; endfunction

   task automatic hdr(input logic [1:0] op, input logic [6:0] a);
      send(1, 1); send({30'd0, op}, 2); send({25'd0, a}, aw());
   endtask

   task automatic rd(input string tag, input logic [6:0] a, input logic [15:0] exp);
      logic [15:0] v = '0;
      int w = wide ? 16 : 8;
      open_f(); hdr(2'b10, a);
      chk({tag, " dummy"}, {31'd0, dout}, 32'd0);
      for (int i = 0; i < w; i++) begin sk_bit(1'b0); v = {v[14:0], dout}; end
      close_f();
      chk(tag, {16'd0, v}, {16'd0, exp});
   endtask

   task automatic wr(input logic [6:0] a, input logic [31:0] d, input int n);
      open_f(); hdr(2'b01, a); send(d, n); close_f();
   endtask

   task automatic ext(input logic [1:0] sel, input logic [15:0] d, input int n);
      open_f(); hdr(2'b00, wide ? {1'b0, sel, 4'd0} : {sel, 5'd0}); send({16'd0, d}, n); close_f();
   endtask

   task automatic t_reset();
      chk("R9 reset dout", {31'd0, dout}, 32'd0);
      open_f(); chk("R4 idle no status", {31'd0, dout}, 32'd0); close_f();
      rd("R7 reset erased", 7'd0, 16'h00ff);
   endtask

   task automatic t_locked();
      wr(7'd5, 32'h3c, 8); wait_prog();
      open_f(); chk("R4 no status when locked", {31'd0, dout}, 32'd0); close_f();
      rd("R4 locked write ignored", 7'd5, 16'h00ff);
   endtask

   task automatic t_write_status();
      ext(2'b11, 16'd0, 0);
      wr(7'd5, 32'h3c, 8);
      open_f(); chk("R9 busy shows 0", {31'd0, dout}, 32'd0);
      wclk(PROG + 10); chk("R9 ready shows 1", {31'd0, dout}, 32'd1);
      sk_bit(1'b1); chk("R10 status cleared", {31'd0, dout}, 32'd0);
      close_f();
      rd("R5 write readback", 7'd5, 16'h003c);
      rd("R2 read other addr", 7'd4, 16'h00ff);
   endtask

   task automatic t_last_word();
      wr(7'd9, 32'habc, 12); wait_prog();
      wr(7'd10, 32'h5, 4);   wait_prog();
      rd("R6 long data keeps last byte", 7'd9, 16'h00bc);
      rd("R6 short data zero filled", 7'd10, 16'h0005);
   endtask

   task automatic t_busy_ignore();
      wr(7'd20, 32'h11, 8);
      wr(7'd21, 32'h22, 8);
      wait_prog();
      rd("R11 first write done", 7'd20, 16'h0011);
      rd("R11 write during busy ignored", 7'd21, 16'h00ff);
   endtask

   task automatic t_erase();
      open_f(); hdr(2'b11, 7'd5); close_f(); wait_prog();
      rd("R7 erase word", 7'd5, 16'h00ff);
      rd("R7 erase leaves neighbour", 7'd9, 16'h00bc);
   endtask

   task automatic t_wide();
      wide = 1'b1; wclk(4);
      wr(7'd3, 32'hbeef, 16); wait_prog();
      rd("R3 wide readback", 7'd3, 16'hbeef);
      wide = 1'b0; wclk(4);
      rd("R3 low byte at 2a", 7'd6, 16'h00ef);
      rd("R3 high byte at 2a+1", 7'd7, 16'h00be);
   endtask

   task automatic t_abort();
      wr(7'd40, 32'h96, 8); wait_prog();
      open_f(); send(32'b110, 3); send(32'b101, 3); close_f();
      open_f(); hdr(2'b01, 7'd41); send(32'h33, 4); close_f(); wait_prog();
      open_f(); send(0, 2); hdr(2'b10, 7'd40);
      begin
         logic [7:0] v = '0;
         for (int i = 0; i < 8; i++) begin sk_bit(1'b0); v = {v[6:0], dout}; end
         chk("R1 leading zeros then read", {24'd0, v}, 32'h96);
      end
      close_f();
      rd("R1 aborted header no effect", 7'd41, 16'h0003);
   endtask

   task automatic t_fill_wipe();
      ext(2'b01, 16'h005a, 8); wait_prog();
      rd("R8 fill addr 0", 7'd0, 16'h005a);
      rd("R8 fill addr 127", 7'd127, 16'h005a);
      ext(2'b10, 16'd0, 0); wait_prog();
      rd("R7 wipe addr 0", 7'd0, 16'h00ff);
      rd("R7 wipe addr 127", 7'd127, 16'h00ff);
   endtask

   task automatic t_lock();
      ext(2'b00, 16'd0, 0);
      wr(7'd30, 32'h77, 8); wait_prog();
      rd("R12 write after disable ignored", 7'd30, 16'h00ff);
   endtask

   initial begin
      wclk(5); rst_n = 1'b1; wclk(5);
      t_reset();
      t_locked();
      t_write_status();
      t_last_word();
      t_busy_ignore();
      t_erase();
      t_wide();
      t_abort();
      t_fill_wipe();
      t_lock();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         nchk++; nerr++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end
endmodule